// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block decides, when the reset pin is released, whether a small processor starts in a serial debug-monitor mode or in normal user mode. It looks at a high-voltage detect flag on the interrupt pin, the ordinary logic level of that pin, the 16-bit reset vector, the level of the host receive line and two clock straps. The decision is captured while reset is held and frozen once reset goes high, so the straps may be reused afterwards. The decision also sets the watchdog enable, the PLL enable and a clock divide code.

In monitor mode the controller runs the entry handshake. A guard window of 24 bus cycles follows reset release, and the communication-select pin must stay low for all of it. After the window the controller takes in exactly eight security bytes from a byte-level receive interface and shows them on a 64-bit output. It then holds the transmit line low for ten bit times as a break and raises a ready flag for the command stage. The bit time is a programmable number of bus cycles.

States: `ST_IDLE` (reset held, straps tracked), `ST_GUARD` (guard window), `ST_INTAKE` (security bytes), `ST_BREAK` (transmit line low), `ST_READY` (waiting for commands), `ST_USER` (user mode) and `ST_FAIL` (guard violated).

Transitions:
- reset low moves any state to `ST_IDLE`.
- `ST_IDLE` moves to `ST_GUARD` in monitor mode and to `ST_USER` otherwise.
- `ST_GUARD` moves to `ST_FAIL` if comm_sel is high, and to `ST_INTAKE` when the window expires.
- `ST_INTAKE` moves to `ST_BREAK` on the eighth byte.
- `ST_BREAK` moves to `ST_READY` after ten bit times.
- `ST_READY`, `ST_USER` and `ST_FAIL` are terminal until the next reset.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The outputs mon_mode, wdog_en, pll_en, clk_div_code and illegal_rst take the values decoded in the last clock cycle in which rst_n was low. Later changes on irq_hv, irq_level, reset_vec, host_line, strap_a or strap_b have no effect on them until the next reset.
- R2: With irq_hv = 1, monitor mode is selected, pll_en = 0 and clk_div_code = {strap_b, strap_a}. A code c means the bus clock is the external clock divided by 2^(c+1).
- R3: With irq_hv = 0, reset_vec = 16'hFFFF and host_line = 1, monitor mode is selected with clk_div_code = 2'b01 (divide by four). pll_en = 0 when irq_level = 1 and pll_en = 1 when irq_level = 0. The straps have no effect in this case.
- R4: With irq_hv = 0, reset_vec = 16'hFFFF and host_line = 0, user mode is selected and illegal_rst = 1.
- R5: With irq_hv = 0 and reset_vec not equal to 16'hFFFF, user mode is selected with illegal_rst = 0, pll_en = 0 and clk_div_code = 2'b00. In user mode, received bytes are ignored, tx_line stays 1 and cmd_ready stays 0.
- R6: wdog_en is 0 in every monitor case and 1 in every user case.
- R7: Call the first rising edge with rst_n high edge 0. If comm_sel is 1 at any of edges 1 through 24, entry_fail rises and the handshake stops: no bytes are stored and cmd_ready never rises. comm_sel high at edge 25 or later does not set entry_fail.
- R8: par_sel follows comm_sel during intake until the first security byte is accepted, then holds. A value of 0 means serial entry and 1 means parallel entry.
- R9: Security bytes are accepted only during intake, and exactly eight are taken. Byte k (counting from 0) lands in sec_bytes[8k+7:8k]. Bytes received during the guard window or after the eighth byte are ignored.
- R10: sec_valid is high for exactly one cycle, the cycle after the edge that accepts the eighth byte.
- R11: From the cycle after the eighth byte, tx_line is 0 for exactly 10 × max(bit_div, 1) clock cycles. It is 1 in all other cycles.
- R12: cmd_ready rises in the cycle where tx_line returns high after the break, and it stays high until reset.
- R13: rst_n low at any time returns the block to idle. The next edge clears cmd_ready, entry_fail, par_sel, sec_bytes, the byte count and the guard counter, and sets tx_line to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Reset pin, active low, sampled on clk |
| irq_hv | input | 1 | High test voltage detected on the interrupt pin |
| irq_level | input | 1 | Logic level of the interrupt pin |
| reset_vec | input | 16 | Contents of the reset vector |
| strap_a | input | 1 | Clock strap, low bit of divide code |
| strap_b | input | 1 | Clock strap, high bit of divide code |
| host_line | input | 1 | Level of the host receive line |
| comm_sel | input | 1 | Communication-select strap (0 serial, 1 parallel) |
| bit_div | input | 16 | Bus cycles per break bit time (0 acts as 1) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| mon_mode | output | 1 | 1 when monitor mode was selected |
| wdog_en | output | 1 | Watchdog enable |
| pll_en | output | 1 | PLL enable |
| clk_div_code | output | 2 | Clock divide code |
| illegal_rst | output | 1 | Blank vector without valid entry conditions |
| entry_fail | output | 1 | Guard window violated |
| par_sel | output | 1 | Captured serial/parallel selection |
| tx_line | output | 1 | Transmit line drive |
| cmd_ready | output | 1 | Ready for commands |
| sec_valid | output | 1 | One-cycle pulse when eight bytes are held |
| sec_bytes | output | 64 | The eight security bytes, byte 0 lowest |

## Verification
The hardest behaviour to reach from the ports is the boundary of the guard window. A comm_sel pulse at edge 24 must abort entry, while the same pulse one edge later must not. The bench counts edges from reset release and sweeps the pulse position over every edge from 1 to 25. The break length is the other hard case, because it depends on bit_div and on the exact cycle of the eighth byte. The bench sends bytes with gaps and stray strobes inside the guard window, then counts the low cycles of tx_line for several divider values, including zero.

// File: rtl/monentry_pkg.sv
`timescale 1ns/1ps
package monentry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_INTAKE,
        ST_BREAK,
        ST_READY,
        ST_USER,
        ST_FAIL
    } ent_state_t;

    typedef struct packed {
        logic       mon;
        logic       illegal;
        logic       pll_on;
        logic [1:0] div_code;
    } boot_cfg_t;

    localparam logic [1:0] DIV_BY_FOUR = 2'b01;

endpackage

// File: rtl/strap_decode.sv
`timescale 1ns/1ps
module strap_decode
    import monentry_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             hv_det,
    input  logic             irq_level,
    input  logic [VEC_W-1:0] reset_vec,
    input  logic             host_line,
    input  logic             strap_a,
    input  logic             strap_b,
    output boot_cfg_t        cfg
);

    localparam logic [VEC_W-1:0] BLANK_VEC = '1;

    logic vec_blank;
    assign vec_blank = (reset_vec == BLANK_VEC);

    always_comb begin
        cfg = '0;
        if (hv_det) begin
            // test-voltage entry: straps pick the divider
            cfg.mon      = 1'b1;
            cfg.div_code = {strap_b, strap_a};
        end else if (vec_blank) begin
            if (host_line) begin
                cfg.mon      = 1'b1;
                cfg.pll_on   = ~irq_level;
                cfg.div_code = DIV_BY_FOUR;
            end else begin
                cfg.illegal  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer #(
    parameter int GUARD_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int GC_W = (GUARD_CYC > 1) ? $clog2(GUARD_CYC) : 1;
    localparam logic [GC_W-1:0] LAST_CNT = GC_W'(GUARD_CYC - 1);

    logic [GC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == LAST_CNT);

    // R7
    guard_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

endmodule

// File: rtl/sec_intake.sv
`timescale 1ns/1ps
module sec_intake #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     rx_valid,
    input  logic [BYTE_W-1:0]        rx_data,
    output logic [NBYTES*BYTE_W-1:0] bytes_flat,
    output logic                     got_any,
    output logic                     last_byte,
    output logic                     full_pulse
);

    localparam int CNT_W = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NBYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             pulse_q;

    assign accept    = enable && rx_valid && (cnt_q < FULL_CNT);
    assign last_byte = accept && (cnt_q == LAST_IDX);
    assign got_any   = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= last_byte;
            if (accept) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_slot
            logic [BYTE_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (accept && (cnt_q == CNT_W'(g))) begin
                    slot_q <= rx_data;
                end
            end
            assign bytes_flat[g*BYTE_W +: BYTE_W] = slot_q;
        end
    endgenerate

    assign full_pulse = pulse_q;

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_pulse |=> !full_pulse);

    // R9
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT));

endmodule

// File: rtl/break_gen.sv
`timescale 1ns/1ps
module break_gen #(
    parameter int DIV_W = 16,
    parameter int BITS  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] bit_div,
    output logic             done
);

    localparam int BIT_W = $clog2(BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

    logic [DIV_W-1:0] cyc_q;
    logic [BIT_W-1:0] bit_q;
    logic [DIV_W-1:0] div_last;
    logic             bit_end;

    assign div_last = (bit_div == '0) ? '0 : (bit_div - 1'b1);
    assign bit_end  = (cyc_q == div_last);
    assign done     = active && bit_end && (bit_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cyc_q <= '0;
            bit_q <= '0;
        end else if (bit_end) begin
            cyc_q <= '0;
            if (bit_q != LAST_BIT) begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R11
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= LAST_BIT);

endmodule

// File: rtl/mon_entry_ctrl.sv
`timescale 1ns/1ps
module mon_entry_ctrl
    import monentry_pkg::*;
#(
    parameter int VEC_W     = 16,
    parameter int GUARD_CYC = 24,
    parameter int NBYTES    = 8,
    parameter int BYTE_W    = 8,
    parameter int DIV_W     = 16,
    parameter int BRK_BITS  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     irq_hv,
    input  logic                     irq_level,
    input  logic [VEC_W-1:0]         reset_vec,
    input  logic                     strap_a,
    input  logic                     strap_b,
    input  logic                     host_line,
    input  logic                     comm_sel,
    input  logic [DIV_W-1:0]         bit_div,
    input  logic                     rx_valid,
    input  logic [BYTE_W-1:0]        rx_data,
    output logic                     mon_mode,
    output logic                     wdog_en,
    output logic                     pll_en,
    output logic [1:0]               clk_div_code,
    output logic                     illegal_rst,
    output logic                     entry_fail,
    output logic                     par_sel,
    output logic                     tx_line,
    output logic                     cmd_ready,
    output logic                     sec_valid,
    output logic [NBYTES*BYTE_W-1:0] sec_bytes
);

    ent_state_t state_q, state_d;
    boot_cfg_t  cfg_d, cfg_q;
    logic       par_q;
    logic       guard_done;
    logic       got_any;
    logic       last_byte;
    logic       brk_done;

    strap_decode #(.VEC_W(VEC_W)) u_decode (
        .hv_det    (irq_hv),
        .irq_level (irq_level),
        .reset_vec (reset_vec),
        .host_line (host_line),
        .strap_a   (strap_a),
        .strap_b   (strap_b),
        .cfg       (cfg_d)
    );

    guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_GUARD),
        .expire (guard_done)
    );

    sec_intake #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_intake (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (state_q == ST_INTAKE),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .bytes_flat (sec_bytes),
        .got_any    (got_any),
        .last_byte  (last_byte),
        .full_pulse (sec_valid)
    );

    break_gen #(.DIV_W(DIV_W), .BITS(BRK_BITS)) u_break (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == ST_BREAK),
        .bit_div (bit_div),
        .done    (brk_done)
    );

    // state register; straps are tracked while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= cfg_d;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INTAKE && !got_any) begin
                par_q <= comm_sel;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cfg_q.mon ? ST_GUARD : ST_USER;
            ST_GUARD: begin
                if (comm_sel)        state_d = ST_FAIL;
                else if (guard_done) state_d = ST_INTAKE;
            end
            ST_INTAKE: if (last_byte) state_d = ST_BREAK;
            ST_BREAK:  if (brk_done)  state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            ST_USER:   state_d = ST_USER;
            ST_FAIL:   state_d = ST_FAIL;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mon_mode     = cfg_q.mon;
        wdog_en      = ~cfg_q.mon;
        pll_en       = cfg_q.pll_on;
        clk_div_code = cfg_q.div_code;
        illegal_rst  = cfg_q.illegal;
        par_sel      = par_q;
        entry_fail   = (state_q == ST_FAIL);
        tx_line      = (state_q != ST_BREAK);
        cmd_ready    = (state_q == ST_READY);
    end

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

    // R4
    illegal_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_rst |-> !mon_mode);

    // R7
    guard_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD && comm_sel) |=> entry_fail);

    // R12
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |=> cmd_ready);

    // R12
    ready_after_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> $past(!tx_line));

    // R5
    user_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER) |-> (tx_line && !sec_valid));

endmodule

// File: tb/mon_entry_ctrl_tb.sv
`timescale 1ns/1ps
module mon_entry_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_hv = 1'b0, irq_level = 1'b1;
    logic [15:0] reset_vec = 16'h1234;
    logic        strap_a = 1'b0, strap_b = 1'b0, host_line = 1'b1;
    logic        comm_sel = 1'b0;
    logic [15:0] bit_div = 16'd1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        mon_mode, wdog_en, pll_en, illegal_rst, entry_fail, par_sel;
    logic        tx_line, cmd_ready, sec_valid;
    logic [1:0]  clk_div_code;
    logic [63:0] sec_bytes;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    mon_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_hv(irq_hv), .irq_level(irq_level),
        .reset_vec(reset_vec), .strap_a(strap_a), .strap_b(strap_b),
        .host_line(host_line), .comm_sel(comm_sel), .bit_div(bit_div),
        .rx_valid(rx_valid), .rx_data(rx_data), .mon_mode(mon_mode),
        .wdog_en(wdog_en), .pll_en(pll_en), .clk_div_code(clk_div_code),
        .illegal_rst(illegal_rst), .entry_fail(entry_fail), .par_sel(par_sel),
        .tx_line(tx_line), .cmd_ready(cmd_ready), .sec_valid(sec_valid),
        .sec_bytes(sec_bytes)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // leaves the bench at the negedge after edge 0
    task automatic apply_reset(input logic hv, input logic lvl, input logic [15:0] vec,
                               input logic host, input logic a, input logic b);
        @(negedge clk);
        irq_hv = hv; irq_level = lvl; reset_vec = vec; host_line = host;
        strap_a = a; strap_b = b; comm_sel = 1'b0; rx_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
    endtask

    task automatic send_byte(input logic [7:0] d);
        rx_valid = 1'b1;
        rx_data  = d;
        step();
        rx_valid = 1'b0;
    endtask

    function automatic logic [4:0] exp_cfg(input logic hv, input logic lvl, input logic [15:0] vec,
                                           input logic host, input logic a, input logic b);
        // {mon, illegal, pll, div[1:0]}
        if (hv) return {1'b1, 1'b0, 1'b0, b, a};
        if (vec == 16'hFFFF) begin
            if (host) return {1'b1, 1'b0, ~lvl, 2'b01};
            return {1'b0, 1'b1, 1'b0, 2'b00};
        end
        return 5'b0;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 29 + k * 13 + 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R13 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] vecs [3];
        logic [4:0]  e;
        logic [63:0] exp_bytes;
        int          n;
        int          divs [5];
        vecs[0] = 16'hFFFF; vecs[1] = 16'hFFFE; vecs[2] = 16'h7FFF;
        divs[0] = 0; divs[1] = 1; divs[2] = 2; divs[3] = 3; divs[4] = 5;

        // R13 reset state
        @(negedge clk);
        step();
        chk(tx_line == 1'b1 && cmd_ready == 1'b0 && sec_valid == 1'b0 && sec_bytes == 64'd0,
            "R13 reset outputs", {tx_line, cmd_ready, sec_valid}, 3'b100);

        // R1..R6 exhaustive decode sweep
        for (int hv = 0; hv < 2; hv++)
            for (int lv = 0; lv < 2; lv++)
                for (int vi = 0; vi < 3; vi++)
                    for (int ho = 0; ho < 2; ho++)
                        for (int st = 0; st < 4; st++) begin
                            apply_reset(1'(hv), 1'(lv), vecs[vi], 1'(ho), st[0], st[1]);
                            e = exp_cfg(1'(hv), 1'(lv), vecs[vi], 1'(ho), st[0], st[1]);
                            chk({mon_mode, illegal_rst, pll_en, clk_div_code} == e,
                                "R2 R3 R4 R5 decode", {mon_mode, illegal_rst, pll_en, clk_div_code}, e);
                            chk(wdog_en == ~e[4], "R6 watchdog", wdog_en, ~e[4]);
                            irq_hv = ~irq_hv; irq_level = ~irq_level; reset_vec = ~reset_vec;
                            host_line = ~host_line; strap_a = ~strap_a; strap_b = ~strap_b;
                            repeat (3) step();
                            chk({mon_mode, illegal_rst, pll_en, clk_div_code} == e,
                                "R1 latched after release", {mon_mode, illegal_rst, pll_en, clk_div_code}, e);
                        end

        // R7 guard window sweep: comm_sel high at edge k
        for (int k = 1; k <= 25; k++) begin
            apply_reset(1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
            repeat (k - 1) step();
            comm_sel = 1'b1;
            step();
            chk(entry_fail == (k <= 24), "R7 guard edge", entry_fail, (k <= 24));
            comm_sel = 1'b0;
            if (k <= 24) begin
                for (int j = 0; j < 8; j++) send_byte(8'hA5);
                repeat (3) step();
                chk(sec_bytes == 64'd0 && cmd_ready == 1'b0 && tx_line == 1'b1,
                    "R7 handshake stopped", sec_bytes, 64'd0);
            end
        end

        // R8 parallel selection captured before first byte
        apply_reset(1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0);
        repeat (24) step();
        comm_sel = 1'b1;
        step();
        chk(par_sel == 1'b1, "R8 par follows", par_sel, 1'b1);
        send_byte(8'h11);
        comm_sel = 1'b0;
        repeat (2) step();
        chk(par_sel == 1'b1, "R8 par held", par_sel, 1'b1);

        // R9..R12 intake and break sweep
        for (int d = 0; d < 5; d++) begin
            bit_div = 16'(divs[d]);
            apply_reset(1'b0, 1'(d % 2), 16'hFFFF, 1'b1, 1'b1, 1'b1);
            for (int i = 0; i < 24; i++) begin
                rx_valid = (i % 3 == 0);
                rx_data  = 8'hEE;
                step();
            end
            rx_valid = 1'b0;
            chk(sec_bytes == 64'd0, "R9 guard bytes ignored", sec_bytes, 64'd0);
            chk(par_sel == 1'b0, "R8 serial", par_sel, 1'b0);
            exp_bytes = '0;
            for (int k = 0; k < 7; k++) begin
                send_byte(pat(d, k));
                exp_bytes[8*k +: 8] = pat(d, k);
                step();
            end
            chk(sec_valid == 1'b0 && tx_line == 1'b1, "R9 seven bytes wait",
                {sec_valid, tx_line}, 2'b01);
            exp_bytes[63:56] = pat(d, 7);
            send_byte(pat(d, 7));
            chk(sec_valid == 1'b1, "R10 pulse", sec_valid, 1'b1);
            chk(sec_bytes == exp_bytes, "R9 byte order", sec_bytes, exp_bytes);
            n = 0;
            while (!tx_line && n < 200) begin
                n++;
                step();
                if (n == 1) chk(sec_valid == 1'b0, "R10 single cycle", sec_valid, 1'b0);
            end
            chk(n == 10 * ((divs[d] == 0) ? 1 : divs[d]), "R11 break length", n,
                10 * ((divs[d] == 0) ? 1 : divs[d]));
            chk(cmd_ready == 1'b1, "R12 ready", cmd_ready, 1'b1);
            for (int k = 0; k < 3; k++) send_byte(8'h5A);
            step();
            chk(sec_bytes == exp_bytes && !sec_valid && cmd_ready && tx_line,
                "R9 R12 extra bytes ignored", sec_bytes, exp_bytes);
        end

        // R13 reset during break
        bit_div = 16'd4;
        apply_reset(1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1);
        repeat (24) step();
        for (int k = 0; k < 8; k++) send_byte(8'h33);
        step();
        chk(tx_line == 1'b0, "R11 in break", tx_line, 1'b0);
        rst_n = 1'b0;
        step();
        chk(tx_line == 1'b1 && cmd_ready == 1'b0 && sec_bytes == 64'd0,
            "R13 reset mid break", sec_bytes, 64'd0);
        rst_n = 1'b1;
        step();
        repeat (23) step();
        comm_sel = 1'b1;
        step();
        chk(entry_fail == 1'b1, "R13 guard counter cleared", entry_fail, 1'b1);
        comm_sel = 1'b0;

        // R5 user mode ignores bytes
        apply_reset(1'b0, 1'b1, 16'h0100, 1'b1, 1'b0, 1'b0);
        repeat (30) step();
        for (int k = 0; k < 8; k++) send_byte(8'h77);
        step();
        chk(sec_bytes == 64'd0 && tx_line && !cmd_ready && !sec_valid,
            "R5 user mode quiet", sec_bytes, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule